// File: doc/BRIEF.md
# Multi-Port Synchronous RAM with Per-Port Access Classes

This block is a synchronous RAM, `W` bits wide and `L` words deep, with a number of ports that is fixed at elaboration. Every port has its own address bus and shares the single clock. A packed parameter gives each port a 3-bit access class. The class decides whether the port can write, whether it can read, whether the read and write share the cycle or take turns, and whether a write spoils reads of the same word by other ports in that cycle. Write-capable ports use a write enable and a `W`-bit write bus. Read-capable ports drive a `W`-bit registered read bus.

All ports of every instance use the same flat bus layout. Unused buses are ignored or held at zero, depending on the class. An instance built with a port count of zero gets one half-duplex read/write port. The depth must be a power of two. A class code above 5 or a depth that is not a power of two stops elaboration with an error.

Top module: `portclass_ram`

## Requirements
- R1: The class of port p is field [3p+2:3p] of `PORT_CLASS`, with codes 0 = half-duplex read/write, 1 = simultaneous read and write, 2 = read only, 3 = write only, 4 = destructive write only, and 5 = half-duplex with destructive write. A port of class 0, 1, 3, 4 or 5 stores its write data at its address on the rising edge when its write enable is high. A read-capable port shows the word at the sampled address on its read bus one clock after sampling.
- R2: A read-only port (class 2) never modifies memory, whatever its write enable and write data carry. It keeps reading while its write enable is high.
- R3: While reset is low, every read bus is zero. The read bus of a write-only port (class 3 or 4) stays zero at all times.
- R4: A half-duplex port (class 0 or 5) reads when its write enable is low. In a cycle where it writes, its read bus keeps its previous value.
- R5: A class 1 port that reads and writes one address in the same cycle returns the old contents. The new value is returned from the following read onward.
- R6: When a class 4 or 5 port writes an address, another port reading that address in the same cycle gets invalid data (all-X in simulation), while the write itself completes. Writes by classes 0, 1 and 3 leave same-cycle reads of that address returning the old contents.
- R7: When several write-capable ports write the same address in one cycle, the data of the highest-numbered port is stored.
- R8: With `NPORTS` set to 0, the instance has exactly one port, of class 0 (half-duplex read/write).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock, rising edge active |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a two-flop synchronizer |
| addr | input | NP*AW | Per-port word address, port p in bits [p*AW +: AW] |
| we | input | NP | Per-port write enable |
| wdata | input | NP*W | Per-port write data, port p in bits [p*W +: W] |
| rdata | output | NP*W | Per-port registered read data, port p in bits [p*W +: W] |

## Verification
The bench targets the cycles where ports interact. It covers a simultaneous read/write port reading the word it is overwriting, a half-duplex port that writes while a read value is pending, a destructive writer hitting the address another port is reading, and two writers landing on the same word. A design that forwards new data would show the fresh word one cycle early on the simultaneous port. A design that lets half-duplex writes refresh the read register would lose the last read value. A design that ignored destructive writes would return the stale word where the value must be invalid, and a wrong priority would keep the lower port's data after a collision. The read-only port is driven with an active write enable, and the default port count instance is exercised as a plain half-duplex RAM.

// File: rtl/pcr_pkg.sv
`timescale 1ns/1ps
package pcr_pkg;

  typedef enum logic [2:0] {
    PC_RW  = 3'd0,
    PC_RAW = 3'd1,
    PC_RO  = 3'd2,
    PC_WO  = 3'd3,
    PC_WD  = 3'd4,
    PC_RWD = 3'd5
  } port_class_e;

  localparam int MAX_PORTS = 16;

  // Cycling 0..5 pattern used as the default class vector.
  function automatic logic [3*MAX_PORTS-1:0] class_cycle();
    logic [3*MAX_PORTS-1:0] v;
    v = '0;
    for (int i = 0; i < MAX_PORTS; i++) begin
      v[3*i +: 3] = 3'(i % 6);
    end
    return v;
  endfunction

  function automatic logic can_write(logic [2:0] c);
    case (c)
      PC_RW, PC_RAW, PC_WO, PC_WD, PC_RWD: return 1'b1;
      default:                             return 1'b0;
    endcase
  endfunction

  function automatic logic always_reads(logic [2:0] c);
    return (c == PC_RO) || (c == PC_RAW);
  endfunction

  function automatic logic is_destructive(logic [2:0] c);
    return (c == PC_WD) || (c == PC_RWD);
  endfunction

endpackage

// File: rtl/pcr_clash_detect.sv
`timescale 1ns/1ps
module pcr_clash_detect #(
  parameter int AW = 4,
  parameter int NP = 6,
  parameter logic [3*NP-1:0] CLS = '0
) (
  input  logic [NP*AW-1:0] addr,
  input  logic [NP-1:0]    we,
  output logic [NP-1:0]    kill
);
  import pcr_pkg::*;

  // kill[q]: some other port performs a destructive write on q's address.
  always_comb begin
    kill = '0;
    for (int q = 0; q < NP; q++) begin
      for (int p = 0; p < NP; p++) begin
        if ((p != q) && is_destructive(CLS[3*p +: 3]) && we[p] &&
            (addr[p*AW +: AW] == addr[q*AW +: AW])) begin
          kill[q] = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pcr_store.sv
`timescale 1ns/1ps
module pcr_store #(
  parameter int W  = 16,
  parameter int L  = 16,
  parameter int AW = 4,
  parameter int NP = 6,
  parameter logic [3*NP-1:0] CLS = '0
) (
  input  logic            clk,
  input  logic [NP*AW-1:0] addr,
  input  logic [NP-1:0]    we,
  input  logic [NP*W-1:0]  wdata,
  output logic [NP*W-1:0]  rd_now
);
  import pcr_pkg::*;

  logic [W-1:0] mem_q [L];
  logic [W-1:0] mem_d [L];

  // Ascending scan: the highest-numbered writer to an address wins.
  always_comb begin
    mem_d = mem_q;
    for (int p = 0; p < NP; p++) begin
      if (we[p] && can_write(CLS[3*p +: 3])) begin
        mem_d[addr[p*AW +: AW]] = wdata[p*W +: W];
      end
    end
  end

  always_ff @(posedge clk) begin
    mem_q <= mem_d;
  end

  // Pre-write contents seen by every port this cycle.
  always_comb begin
    for (int p = 0; p < NP; p++) begin
      rd_now[p*W +: W] = mem_q[addr[p*AW +: AW]];
    end
  end

endmodule

// File: rtl/pcr_read_port.sv
`timescale 1ns/1ps
module pcr_read_port #(
  parameter int W = 16,
  parameter logic [2:0] CLASS = 3'd0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic         kill,
  input  logic [W-1:0] rd_now,
  output logic [W-1:0] rdata
);
  import pcr_pkg::*;

  logic         load;
  logic [W-1:0] rdata_d;
  logic [W-1:0] rdata_q;

  always_comb begin
    case (CLASS)
      PC_RO, PC_RAW: load = 1'b1;
      PC_RW, PC_RWD: load = ~we;
      default:       load = 1'b0;
    endcase
  end

  always_comb begin
    rdata_d = rdata_q;
    if (load) begin
      rdata_d = kill ? {W{1'bx}} : rd_now;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/portclass_ram.sv
`timescale 1ns/1ps
module portclass_ram #(
  parameter int W      = 16,
  parameter int L      = 16,
  parameter int NPORTS = 6,
  localparam int NP    = (NPORTS == 0) ? 1 : NPORTS,
  localparam int AW    = (L > 1) ? $clog2(L) : 1,
  localparam logic [3*pcr_pkg::MAX_PORTS-1:0] CLASS_SEQ = pcr_pkg::class_cycle(),
  parameter logic [3*NP-1:0] PORT_CLASS = CLASS_SEQ[3*NP-1:0]
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NP*AW-1:0] addr,
  input  logic [NP-1:0]    we,
  input  logic [NP*W-1:0]  wdata,
  output logic [NP*W-1:0]  rdata
);

  localparam logic [3*NP-1:0] EFF_CLASS = (NPORTS == 0) ? {NP{3'd0}} : PORT_CLASS;

  if ((1 << AW) != L || L < 2) begin : g_bad_depth
    $error("portclass_ram: depth must be a power of two of at least 2");
  end

  for (genvar p = 0; p < NP; p++) begin : g_class_chk
    if (EFF_CLASS[3*p +: 3] > 3'd5) begin : g_bad_class
      $error("portclass_ram: illegal class code on a port");
    end
  end

  // Reset: asynchronous assertion, synchronous release.
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [NP-1:0]   kill;
  logic [NP*W-1:0] rd_now;

  pcr_clash_detect #(.AW(AW), .NP(NP), .CLS(EFF_CLASS)) u_clash (
    .addr (addr),
    .we   (we),
    .kill (kill)
  );

  pcr_store #(.W(W), .L(L), .AW(AW), .NP(NP), .CLS(EFF_CLASS)) u_store (
    .clk    (clk),
    .addr   (addr),
    .we     (we),
    .wdata  (wdata),
    .rd_now (rd_now)
  );

  for (genvar p = 0; p < NP; p++) begin : g_port
    pcr_read_port #(.W(W), .CLASS(EFF_CLASS[3*p +: 3])) u_rd (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .we     (we[p]),
      .kill   (kill[p]),
      .rd_now (rd_now[p*W +: W]),
      .rdata  (rdata[p*W +: W])
    );
  end

endmodule

// File: rtl/pcr_checker.sv
`timescale 1ns/1ps
module pcr_checker #(
  parameter int W  = 16,
  parameter int AW = 4,
  parameter int NP = 6,
  parameter logic [3*NP-1:0] CLS = '0
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NP*AW-1:0] addr,
  input logic [NP-1:0]    we,
  input logic [NP*W-1:0]  wdata,
  input logic [NP*W-1:0]  rdata,
  input logic [NP-1:0]    kill
);
  import pcr_pkg::*;

  logic [NP-1:0] we_eff;
  always_comb begin
    for (int p = 0; p < NP; p++) we_eff[p] = we[p] && can_write(CLS[3*p +: 3]);
  end

  for (genvar p = 0; p < NP; p++) begin : g_p
    localparam logic [2:0] C = CLS[3*p +: 3];

    if (C == PC_WO || C == PC_WD) begin : g_wonly
      // R3
      a_r3_write_only_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        rdata[p*W +: W] == '0);
    end

    if (C == PC_RW || C == PC_RWD) begin : g_half
      // R4
      a_r4_hold_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        we[p] |=> $stable(rdata[p*W +: W]));
    end

    if (C == PC_RAW) begin : g_raw
      // R5: sole write, then a plain read of the same word returns the new data
      a_r5_raw_new_value: assert property (@(posedge clk) disable iff (!rst_n)
        (we_eff[p] && $countones(we_eff) == 1) ##1
        (addr[p*AW +: AW] == $past(addr[p*AW +: AW]) && we_eff == '0)
        |=> rdata[p*W +: W] == $past(wdata[p*W +: W], 2));
    end

    for (genvar r = p + 1; r < NP; r++) begin : g_r
      localparam logic [2:0] CR = CLS[3*r +: 3];
      if (always_reads(C) && always_reads(CR)) begin : g_pair
        // R1: two reads of one word in one cycle agree
        a_r1_same_word_agree: assert property (@(posedge clk) disable iff (!rst_n)
          (addr[p*AW +: AW] == addr[r*AW +: AW] && !kill[p] && !kill[r])
          |=> rdata[p*W +: W] === rdata[r*W +: W]);
      end
      if (can_write(C) && can_write(CR)) begin : g_wpair
        // R7: same-address write collision
        c_r7_write_collision: cover property (@(posedge clk) disable iff (!rst_n)
          we_eff[p] && we_eff[r] && addr[p*AW +: AW] == addr[r*AW +: AW]);
      end
    end
  end

endmodule

bind portclass_ram pcr_checker #(
  .W(W), .AW(AW), .NP(NP), .CLS(EFF_CLASS)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .addr  (addr),
  .we    (we),
  .wdata (wdata),
  .rdata (rdata),
  .kill  (kill)
);

// File: tb/portclass_ram_test.sv
`timescale 1ns/1ps
module portclass_ram_test;
  localparam int W  = 16;
  localparam int L  = 16;
  localparam int NP = 6;
  localparam int AW = 4;
  localparam int DL = 8;
  localparam int DAW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic            rst_n;
  logic [NP*AW-1:0] addr;
  logic [NP-1:0]    we;
  logic [NP*W-1:0]  wdata;
  logic [NP*W-1:0]  rdata;

  logic [DAW-1:0] d_addr;
  logic           d_we;
  logic [W-1:0]   d_wdata;
  logic [W-1:0]   d_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // Default classes: port0 RW, 1 RAW, 2 RO, 3 WO, 4 WD, 5 RWD
  portclass_ram #(.W(W), .L(L), .NPORTS(NP)) uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata), .rdata(rdata)
  );

  portclass_ram #(.W(W), .L(DL), .NPORTS(0)) uut_dflt (
    .clk(clk), .rst_n(rst_n), .addr(d_addr), .we(d_we), .wdata(d_wdata), .rdata(d_rdata)
  );

  function automatic logic [W-1:0] rd(int p);
    return rdata[p*W +: W];
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_spoiled(string req, logic [W-1:0] act, logic [W-1:0] stale);
    n_cmp++;
    if (act === stale) begin
      n_bad++;
      $display("FAIL %s: actual %h expected anything but %h", req, act, stale);
    end
  endtask

  task automatic set(int p, logic [AW-1:0] a, logic w, logic [W-1:0] d);
    addr[p*AW +: AW] = a;
    we[p]            = w;
    wdata[p*W +: W]  = d;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic poke(int p, logic [AW-1:0] a, logic [W-1:0] d);
    set(p, a, 1'b1, d);
    step();
    we[p] = 1'b0;
  endtask

  task automatic park();
    we = '0;
    for (int p = 0; p < NP; p++) addr[p*AW +: AW] = AW'(15 - p);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    addr = '0; we = '0; wdata = '0;
    d_addr = '0; d_we = 1'b0; d_wdata = '0;
    repeat (3) step();
    for (int p = 0; p < NP; p++) check("R3 reset read bus", rd(p), '0);
    check("R3 reset read bus default instance", d_rdata, '0);
    rst_n = 1'b1;
    repeat (3) step();
    park();
  endtask

  task automatic t_write_read();
    poke(0, 4'd3, 16'h1234);
    poke(3, 4'd7, 16'hBEEF);
    set(2, 4'd3, 1'b0, '0);
    step();
    check("R1 RO read after RW write", rd(2), 16'h1234);
    set(2, 4'd7, 1'b0, '0);
    step();
    check("R1 RO read after WO write", rd(2), 16'hBEEF);
    set(0, 4'd7, 1'b0, '0);
    step();
    check("R1 RW read", rd(0), 16'hBEEF);
    park();
  endtask

  task automatic t_ro_ignores();
    set(2, 4'd3, 1'b1, 16'hDEAD);
    step();
    check("R2 RO reads while we high", rd(2), 16'h1234);
    set(2, 4'd3, 1'b0, '0);
    step();
    check("R2 RO write ignored", rd(2), 16'h1234);
    park();
  endtask

  task automatic t_half_duplex();
    set(0, 4'd3, 1'b0, '0);
    step();
    check("R4 RW read", rd(0), 16'h1234);
    set(0, 4'd5, 1'b1, 16'h5555);
    step();
    check("R4 RW holds during write", rd(0), 16'h1234);
    set(0, 4'd5, 1'b0, '0);
    step();
    check("R4 RW reads written word", rd(0), 16'h5555);
    set(5, 4'd7, 1'b0, '0);
    step();
    check("R4 RWD read", rd(5), 16'hBEEF);
    set(5, 4'd6, 1'b1, 16'h6666);
    step();
    check("R4 RWD holds during write", rd(5), 16'hBEEF);
    set(5, 4'd6, 1'b0, '0);
    step();
    check("R4 RWD reads written word", rd(5), 16'h6666);
    park();
  endtask

  task automatic t_raw();
    poke(1, 4'd9, 16'h1111);
    set(1, 4'd9, 1'b1, 16'h2222);
    step();
    check("R5 RAW returns old contents", rd(1), 16'h1111);
    set(1, 4'd9, 1'b0, '0);
    step();
    check("R5 RAW new value next cycle", rd(1), 16'h2222);
    park();
  endtask

  task automatic t_destructive();
    poke(0, 4'd10, 16'hA5A5);
    park();
    set(4, 4'd10, 1'b1, 16'h0F0F);
    set(2, 4'd10, 1'b0, '0);
    step();
    check_spoiled("R6 WD spoils RO read", rd(2), 16'hA5A5);
    we[4] = 1'b0;
    step();
    check("R6 WD write lands", rd(2), 16'h0F0F);
    set(3, 4'd10, 1'b1, 16'h7777);
    step();
    check("R6 WO write leaves read old", rd(2), 16'h0F0F);
    we[3] = 1'b0;
    step();
    check("R6 WO write lands", rd(2), 16'h7777);
    park();
    poke(0, 4'd11, 16'h3C3C);
    park();
    set(1, 4'd11, 1'b0, '0);
    set(5, 4'd11, 1'b1, 16'h9999);
    step();
    check_spoiled("R6 RWD spoils RAW read", rd(1), 16'h3C3C);
    we[5] = 1'b0;
    step();
    check("R6 RWD write lands", rd(1), 16'h9999);
    park();
  endtask

  task automatic t_collision();
    set(0, 4'd12, 1'b1, 16'hAAAA);
    set(3, 4'd12, 1'b1, 16'hBBBB);
    step();
    park();
    set(2, 4'd12, 1'b0, '0);
    step();
    check("R7 port3 beats port0", rd(2), 16'hBBBB);
    park();
    set(1, 4'd13, 1'b1, 16'h1313);
    set(4, 4'd13, 1'b1, 16'hCCCC);
    step();
    park();
    set(2, 4'd13, 1'b0, '0);
    step();
    check("R7 port4 beats port1", rd(2), 16'hCCCC);
    check("R3 WO read bus zero", rd(3), '0);
    check("R3 WD read bus zero", rd(4), '0);
    park();
  endtask

  task automatic t_default_ports();
    d_addr = 3'd2; d_we = 1'b1; d_wdata = 16'h4242;
    step();
    d_we = 1'b0;
    step();
    check("R8 default port write/read", d_rdata, 16'h4242);
    d_we = 1'b1; d_wdata = 16'h0001;
    step();
    check("R8 default port is half-duplex", d_rdata, 16'h4242);
    d_we = 1'b0;
    step();
    check("R8 default port reads new word", d_rdata, 16'h0001);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_write_read();
    t_ro_ignores();
    t_half_duplex();
    t_raw();
    t_destructive();
    t_collision();
    t_default_ports();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule